// File: doc/BRIEF.md
# Hashed Requester-ID to Stream-ID Lookup

This block turns a 16-bit PCIe requester ID (bus, device and function) into a stream ID for an IOMMU. The translations live in a 256-slot table that is indexed by a CRC-8 hash of the requester ID. When two requester IDs share a home slot, their entries form a chain: each entry holds the index of the slot that follows it.

Software fills the table and an 8-bit base stream ID through a small word-wide register port. A lookup request arrives on a valid/ready handshake. The block hashes the requester ID and reads the home slot. It compares the stored requester ID with the request and follows the chain links until it finds a match or the chain ends. The answer is a hit flag and a stream ID, which is the base plus the offset held in the matching entry.

The table is one synchronous single-port RAM. After reset, or after a clear command, a sweep writes zero into every slot. While the sweep runs, neither the register port nor the lookup port accepts anything.

Top module: `rid_sid_lookup`

## Requirements
- R1: The home slot of a requester ID is its CRC-8 with polynomial 0x07, initial value 0 and no final inversion. The bits are taken most significant first, high byte then low byte, so the bits go in from bit 15 down to bit 0.
- R2: In the register port, byte address slot*4 (address bit 10 clear, slot in bits 9:2) reaches a table word, and address 0x400 holds the base stream ID in bits 7:0. Writing 0x404 with bit 0 set starts a clear. An accepted read (reg_en, reg_ready, reg_we low) returns its data with reg_rvalid high in the next cycle.
- R3: A table word holds the requester ID in bits 31:16, the stream offset in bits 15:8 and the next-slot index in bits 7:0. When a visited entry's requester ID equals the request, the result is a hit with res_sid equal to base plus offset, modulo 256.
- R4: A lookup whose home slot holds an all-zero word reports a miss with res_sid 0.
- R5: When an entry does not match, the walk moves to the slot named by its next-slot field. A mismatching entry whose next-slot field is 0 ends the walk with a miss and res_sid 0.
- R6: A walk reads at most 256 entries. If none of them matches, it reports a miss with res_sid 0.
- R7: Each chain step is one table read taking two cycles. Counting from the clock edge that accepts the request, a walk of k reads raises res_valid after 2k edges when nothing stalls it. res_valid is a single-cycle pulse.
- R8: After reset and after a clear command, every slot reads as zero. While the clear sweep runs, reg_ready and lk_ready stay low.
- R9: While reg_en is high, lk_ready is low and a walk in progress makes no table read. The walk resumes afterwards with an unchanged result.
- R10: Only one lookup is in flight. lk_ready stays low from the accepting edge until the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 11 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Register port can accept an access (low during a clear sweep) |
| reg_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| reg_rdata | output | 32 | Read data |
| lk_valid | input | 1 | Lookup request valid |
| lk_bdf | input | 16 | Requester ID to translate |
| lk_ready | output | 1 | Lookup request accepted when high together with lk_valid |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | Result is a match |
| res_sid | output | 8 | Stream ID (0 on a miss) |

## Verification
The bench builds a real chain from two requester IDs that hash to the same slot, then looks up a third colliding ID that is not in the table. A design that ignored the next-slot links would miss the second entry, and one that ignored a zero link would run on past the end of the chain. A self-linked entry that never matches exercises the step limit: a design without the limit would hang, and one with an off-by-one limit would show a latency other than 512 cycles. A register read held high in the middle of a walk must stretch the latency by exactly the stall cycles and leave the result unchanged. The bench also checks that the base-plus-offset sum wraps, and that a clear really zeroes slots that were written before it.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_READ  = 2'd1,
    WK_CHECK = 2'd2
  } walk_state_e;

  typedef enum logic [1:0] {
    RS_TABLE = 2'd0,
    RS_BASE  = 2'd1,
    RS_NONE  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/rsl_hash.sv
module rsl_hash #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 8,
  parameter logic [OUT_W-1:0] POLY = 8'h07
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] crc
);
  // Serial CRC unrolled over all input bits, most significant bit first.
  always_comb begin
    logic [OUT_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb = c[OUT_W-1] ^ din[i];
      c  = {c[OUT_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    crc = c;
  end
endmodule

// File: rtl/rsl_table.sv
module rsl_table #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/rsl_walker.sv
module rsl_walker
  import rsl_pkg::*;
#(
  parameter int BDF_W  = 16,
  parameter int SLOT_W = 8,
  parameter int SID_W  = 8,
  parameter logic [SLOT_W-1:0] POLY = 8'h07
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            lk_valid,
  input  logic [BDF_W-1:0]                lk_bdf,
  output logic                            lk_ready,
  input  logic                            free,
  input  logic [SID_W-1:0]                base,
  input  logic [BDF_W+SID_W+SLOT_W-1:0]   ram_q,
  output logic [SLOT_W-1:0]               rd_slot,
  output logic                            res_valid,
  output logic                            res_hit,
  output logic [SID_W-1:0]                res_sid
);
  localparam int ENTRY_W = BDF_W + SID_W + SLOT_W;

  walk_state_e       st;
  logic [BDF_W-1:0]  key;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] steps;
  logic [SLOT_W-1:0] home;

  logic [BDF_W-1:0]  e_bdf;
  logic [SID_W-1:0]  e_off;
  logic [SLOT_W-1:0] e_next;
  logic              empty, match, last;

  rsl_hash #(.IN_W(BDF_W), .OUT_W(SLOT_W), .POLY(POLY)) u_hash (
    .din (lk_bdf),
    .crc (home)
  );

  always_comb begin
    e_bdf  = ram_q[ENTRY_W-1 -: BDF_W];
    e_off  = ram_q[SLOT_W +: SID_W];
    e_next = ram_q[SLOT_W-1:0];
    empty  = (ram_q == '0);
    match  = !empty && (e_bdf == key);
    last   = empty || match || (e_next == '0) || (steps == '1);
  end

  assign lk_ready = (st == WK_IDLE) && free;
  assign rd_slot  = slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= WK_IDLE;
      key       <= '0;
      slot      <= '0;
      steps     <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_sid   <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        WK_IDLE: begin
          if (lk_valid && lk_ready) begin
            key   <= lk_bdf;
            slot  <= home;
            steps <= '0;
            st    <= WK_READ;
          end
        end
        WK_READ: begin
          if (free) st <= WK_CHECK;
        end
        WK_CHECK: begin
          if (last) begin
            res_valid <= 1'b1;
            res_hit   <= match;
            res_sid   <= match ? base + e_off : '0;
            st        <= WK_IDLE;
          end else begin
            slot  <= e_next;
            steps <= steps + 1'b1;
            st    <= WK_READ;
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rid_sid_lookup.sv
module rid_sid_lookup
  import rsl_pkg::*;
#(
  parameter int BDF_W  = 16,
  parameter int SLOT_W = 8,
  parameter int SID_W  = 8,
  parameter logic [SLOT_W-1:0] POLY = 8'h07,
  localparam int ENTRY_W = BDF_W + SID_W + SLOT_W,
  localparam int ADDR_W  = SLOT_W + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_en,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [ENTRY_W-1:0] reg_wdata,
  output logic               reg_ready,
  output logic               reg_rvalid,
  output logic [ENTRY_W-1:0] reg_rdata,
  input  logic               lk_valid,
  input  logic [BDF_W-1:0]   lk_bdf,
  output logic               lk_ready,
  output logic               res_valid,
  output logic               res_hit,
  output logic [SID_W-1:0]   res_sid
);
  localparam int DEPTH = 2 ** SLOT_W;
  localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(DEPTH * 4);
  localparam logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(DEPTH * 4 + 4);

  logic               clearing;
  logic [SLOT_W-1:0]  clr_idx;
  logic [SID_W-1:0]   base_q;
  rd_src_e            rd_src_q;
  logic               rvalid_q;

  logic               acc, is_tab, is_base, is_clr, free;
  logic [SLOT_W-1:0]  walk_slot, ram_addr;
  logic               ram_we;
  logic [ENTRY_W-1:0] ram_wd, ram_q;

  always_comb begin
    acc     = reg_en && !clearing;
    is_tab  = !reg_addr[ADDR_W-1];
    is_base = (reg_addr == BASE_ADDR);
    is_clr  = (reg_addr == CLR_ADDR);
    free    = !reg_en && !clearing;
    if (clearing)  ram_addr = clr_idx;
    else if (acc)  ram_addr = reg_addr[SLOT_W+1:2];
    else           ram_addr = walk_slot;
    ram_we = clearing || (acc && reg_we && is_tab);
    ram_wd = clearing ? '0 : reg_wdata;
  end

  rsl_table #(.AW(SLOT_W), .DW(ENTRY_W)) u_table (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wd),
    .q     (ram_q)
  );

  rsl_walker #(.BDF_W(BDF_W), .SLOT_W(SLOT_W), .SID_W(SID_W), .POLY(POLY)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_bdf    (lk_bdf),
    .lk_ready  (lk_ready),
    .free      (free),
    .base      (base_q),
    .ram_q     (ram_q),
    .rd_slot   (walk_slot),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_sid   (res_sid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      clr_idx  <= '0;
      base_q   <= '0;
      rd_src_q <= RS_NONE;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= acc && !reg_we;
      if (acc) rd_src_q <= is_tab ? RS_TABLE : (is_base ? RS_BASE : RS_NONE);
      if (acc && reg_we && is_base) base_q <= reg_wdata[SID_W-1:0];
      if (clearing) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == '1) clearing <= 1'b0;
      end else if (acc && reg_we && is_clr && reg_wdata[0]) begin
        clearing <= 1'b1;
        clr_idx  <= '0;
      end
    end
  end

  always_comb begin
    case (rd_src_q)
      RS_TABLE: reg_rdata = ram_q;
      RS_BASE:  reg_rdata = {{(ENTRY_W-SID_W){1'b0}}, base_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign reg_ready  = !clearing;
  assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/rsl_checker.sv
module rsl_checker #(
  parameter int SID_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_en,
  input logic             reg_we,
  input logic             reg_ready,
  input logic             reg_rvalid,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             res_valid,
  input logic             res_hit,
  input logic [SID_W-1:0] res_sid
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst)                       pending <= 1'b0;
    else if (lk_valid && lk_ready) pending <= 1'b1;
    else if (res_valid)            pending <= 1'b0;
  end

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_sid == '0));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    !reg_ready |-> !lk_ready);

  assert_reg_priority_R9: assert property (@(posedge clk) disable iff (rst)
    reg_en |-> !lk_ready);

  assert_read_data_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_en && reg_ready && !reg_we) |=> reg_rvalid);

  assert_one_in_flight_R10: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_ready) |=> !lk_ready);

  assert_result_owned_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> pending);
endmodule

bind rid_sid_lookup rsl_checker #(.SID_W(SID_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_en     (reg_en),
  .reg_we     (reg_we),
  .reg_ready  (reg_ready),
  .reg_rvalid (reg_rvalid),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_sid    (res_sid)
);

// File: tb/rid_sid_lookup_tb.sv
`timescale 1ns/1ps
module rid_sid_lookup_tb;
  localparam logic [10:0] BASE_A = 11'h400;
  localparam logic [10:0] CLR_A  = 11'h404;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [10:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready, reg_rvalid;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_bdf = '0;
  logic        lk_ready, res_valid, res_hit;
  logic [7:0]  res_sid;

  int errors = 0;
  int checks = 0;

  logic [15:0] bA, bB, bC, bD, bF;
  logic [7:0]  hA, s2, hL;

  always #2 clk = ~clk;

  rid_sid_lookup u_dut (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_bdf(lk_bdf), .lk_ready(lk_ready),
    .res_valid(res_valid), .res_hit(res_hit), .res_sid(res_sid)
  );

  function automatic logic [7:0] crc8(input logic [15:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      logic t = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (t ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [31:0] ent(input logic [15:0] b, input logic [7:0] off,
                                      input logic [7:0] nxt);
    return {b, off, nxt};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!reg_ready && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic reg_wr(input logic [10:0] a, input logic [31:0] d);
    wait_ready();
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [10:0] a, output logic [31:0] d);
    wait_ready();
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    check(reg_rvalid == 1'b1, "R2 rvalid", 32'(reg_rvalid), 1);
    d = reg_rdata;
    reg_en = 1'b0;
  endtask

  task automatic lookup(input logic [15:0] b, input int stall, output logic hit,
                        output logic [7:0] sid, output int lat);
    int n = 0;
    lk_valid = 1'b1; lk_bdf = b;
    while (!lk_ready && n < 1000) begin @(negedge clk); n++; end
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_ready == 1'b0, "R10 busy", 32'(lk_ready), 0);
    if (stall > 0) begin reg_en = 1'b1; reg_we = 1'b0; reg_addr = {1'b0, hA, 2'b00}; end
    lat = 0;
    hit = 1'b0; sid = '0;
    while (lat < 2000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == stall) reg_en = 1'b0;
      if (res_valid) begin hit = res_hit; sid = res_sid; break; end
    end
    @(negedge clk);
    check(res_valid == 1'b0, "R7 pulse", 32'(res_valid), 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(reg_ready == 1'b0, "R8 sweep after reset", 32'(reg_ready), 0);
    check(lk_ready == 1'b0, "R8 lookup blocked", 32'(lk_ready), 0);
    check(res_valid == 1'b0, "R7 idle", 32'(res_valid), 0);
    reg_rd(11'h000, d); check(d == 0, "R8 slot0 zero", d, 0);
    reg_rd(11'h3FC, d); check(d == 0, "R8 slot255 zero", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_wr(BASE_A, 32'h10);
    reg_rd(BASE_A, d); check(d == 32'h10, "R2 base readback", d, 32'h10);
    reg_wr({1'b0, hA, 2'b00}, ent(bA, 8'h05, 8'h00));
    reg_rd({1'b0, hA, 2'b00}, d);
    check(d == ent(bA, 8'h05, 8'h00), "R2 entry readback", d, ent(bA, 8'h05, 8'h00));
  endtask

  task automatic t_home_hit();
    logic h; logic [7:0] s; int l;
    lookup(bA, 0, h, s, l);
    check(h == 1'b1, "R1 hit at CRC home slot", 32'(h), 1);
    check(s == 8'h15, "R3 base plus offset", 32'(s), 32'h15);
    check(l == 2, "R7 latency one read", l, 2);
  endtask

  task automatic t_empty();
    logic h; logic [7:0] s; int l;
    lookup(bD, 0, h, s, l);
    check(h == 1'b0 && s == 8'h00, "R4 empty home miss", {h, s}, 0);
    check(l == 2, "R4 latency", l, 2);
  endtask

  task automatic t_chain();
    logic h; logic [7:0] s; int l;
    reg_wr({1'b0, s2, 2'b00}, ent(bB, 8'h07, 8'h00));
    reg_wr({1'b0, hA, 2'b00}, ent(bA, 8'h05, s2));
    lookup(bB, 0, h, s, l);
    check(h == 1'b1 && s == 8'h17, "R5 chained hit", {h, s}, {1'b1, 8'h17});
    check(l == 4, "R7 latency two reads", l, 4);
    lookup(bC, 0, h, s, l);
    check(h == 1'b0 && s == 8'h00, "R5 chain end miss", {h, s}, 0);
    check(l == 4, "R5 end after two reads", l, 4);
  endtask

  task automatic t_wrap();
    logic h; logic [7:0] s; int l;
    reg_wr(BASE_A, 32'hFE);
    lookup(bB, 0, h, s, l);
    check(h == 1'b1 && s == 8'h05, "R3 sum wraps", {h, s}, {1'b1, 8'h05});
  endtask

  task automatic t_stall();
    logic h; logic [7:0] s; int l;
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = 11'h000; lk_valid = 1'b1; lk_bdf = bB;
    #0.5;
    check(lk_ready == 1'b0, "R9 reg access blocks lookup", 32'(lk_ready), 0);
    @(negedge clk);
    reg_en = 1'b0; lk_valid = 1'b0;
    @(negedge clk);
    lookup(bB, 3, h, s, l);
    check(h == 1'b1 && s == 8'h05, "R9 result after stall", {h, s}, {1'b1, 8'h05});
    check(l == 7, "R9 stall stretches walk", l, 7);
  endtask

  task automatic t_limit();
    logic h; logic [7:0] s; int l;
    reg_wr({1'b0, hL, 2'b00}, ent(bF ^ 16'h0001, 8'h01, hL));
    lookup(bF, 0, h, s, l);
    check(h == 1'b0 && s == 8'h00, "R6 step limit miss", {h, s}, 0);
    check(l == 512, "R6 exactly 256 reads", l, 512);
  endtask

  task automatic t_clear();
    logic [31:0] d; logic h; logic [7:0] s; int l;
    reg_wr(CLR_A, 32'h1);
    check(reg_ready == 1'b0, "R8 clear sweep running", 32'(reg_ready), 0);
    check(lk_ready == 1'b0, "R8 lookup held in clear", 32'(lk_ready), 0);
    reg_rd({1'b0, hA, 2'b00}, d); check(d == 0, "R8 cleared home", d, 0);
    reg_rd({1'b0, s2, 2'b00}, d); check(d == 0, "R8 cleared chain", d, 0);
    reg_rd({1'b0, hL, 2'b00}, d); check(d == 0, "R8 cleared loop", d, 0);
    lookup(bA, 0, h, s, l);
    check(h == 1'b0, "R8 lookup after clear", 32'(h), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bA = 16'h0100;
    while (crc8(bA) >= 8'hFE || crc8(bA) == 8'h00) bA++;
    hA = crc8(bA);
    s2 = hA + 8'd1;
    bB = bA ^ 16'h0107;
    bC = bA ^ 16'h020E;
    bD = 16'h0A00;
    while (crc8(bD) == hA || crc8(bD) == s2) bD++;
    bF = 16'h1300;
    while (crc8(bF) == hA || crc8(bF) == s2 || crc8(bF) == crc8(bD)) bF++;
    hL = crc8(bF);

    t_reset();
    t_regs();
    t_home_hit();
    t_empty();
    t_chain();
    t_wrap();
    t_stall();
    t_limit();
    t_clear();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule